// File: doc/BRIEF.md
# Serial Byte Controller Busy-Lock Arbiter

This block sits between a host register port and the transmit and receive engines of a serial byte controller that can run in LIN or UART framing. It keeps a busy flag that covers every transmitted byte, and it decides, cycle by cycle, which host register writes reach the register file and which commands act on the engines. It is the only path by which a control write becomes a command to the engines.

While a byte is being sent, configuration writes are held off and the data register cannot be overwritten. Commands written during that time fall into three classes. A software reset or a kill (enable bit cleared, or command bit 2 cleared) acts at once. An abort (command bits [1:0] = 00) is held in a pending bit until the byte ends. Any other command is refused, and a sticky overrun error flag records that it was refused. Reception never raises busy. The host clears the overrun flag with a write-one-to-clear access to the error register.

Top module: `lin_busy_gate`

## Requirements
- R1: A pulse on `tx_start_i` sets `busy_o` from the next cycle. `busy_o` then stays high until the cycle after `tx_done_i`, unless a kill or reset intervenes.
- R2: `rx_byte_i` has no effect on `busy_o`.
- R3: With no transfer in progress, a host write raises `we_o[addr]` in the same cycle. While `busy_o` is high, writes to the locked registers (control configuration 0, baud 2 and 3, length 4, identifier 5, data 7) give `we_o` = 0. Writes to the error register 1 and the spare register 6 still pass.
- R4: Some control writes carry enable (bit 3) = 1, command bit 2 = 1, command bits [1:0] != 00 and soft reset (bit 4) = 0. If such a write arrives while busy, it is refused: `cmd_o` and `enable_o` keep their values, `busy_o` is unchanged, and `ovr_err_o` is set on the next cycle.
- R5: `ovr_err_o` stays set until a write to address 1 with data bit 0 = 1. A write there with bit 0 = 0 leaves it set.
- R6: A control write with bit 4 = 0, bit 3 = 1 and command = 100 is an abort. While busy, it updates `cmd_o` at once and pulses `abort_o` for one cycle, in the cycle after `tx_done_i`. When no transfer is in progress, `abort_o` pulses in the next cycle.
- R7: A control write with bit 4 = 0 and either bit 3 = 0 or command bit 2 = 0 is a kill. It pulses `kill_o` in the next cycle, clears `busy_o` in that same cycle (even over a simultaneous `tx_start_i`), and discards a pending abort.
- R8: A control write with bit 4 = 1 pulses `reset_o` in the next cycle. It clears `busy_o`, `ovr_err_o`, `cmd_o` and `enable_o`. It takes priority over a kill.
- R9: A control write with no transfer in progress loads `cmd_o` (bits 2:0) and `enable_o` (bit 3) on the next cycle.
- R10: While `rst_ni` is low, every output register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | AW (3) | Host write register index |
| wr_data_i | input | 5 | Low host data bits: command [2:0], enable [3], soft reset [4] |
| tx_start_i | input | 1 | Transmit engine begins a byte |
| tx_done_i | input | 1 | Transmit engine finished a byte |
| rx_byte_i | input | 1 | Receive engine is taking a byte |
| busy_o | output | 1 | Transfer in progress |
| we_o | output | NREG (8) | Per-register write enables |
| cmd_o | output | 3 | Accepted command field |
| enable_o | output | 1 | Accepted enable bit |
| ovr_err_o | output | 1 | Sticky refused-command flag |
| kill_o | output | 1 | One-cycle kill strobe |
| abort_o | output | 1 | One-cycle abort strobe |
| reset_o | output | 1 | One-cycle soft reset strobe |

## Verification
The bench builds the block with the default parameters: eight registers, control at index 0, error flag at index 1, and a lock mask of 0xBD. With that mask the error register and the spare index 6 stay writable during a transfer. Both the blocked and the open write paths can therefore be seen at `we_o` in the same busy window. Eight registers also leave room to reach the deferred abort, a kill that cancels a pending abort, and a kill racing a transmit start.

// File: rtl/lin_busy_pkg.sv
package lin_busy_pkg;
  localparam int CMD_W     = 3;
  localparam int EN_BIT    = 3;
  localparam int SWRES_BIT = 4;
  localparam int FLD_W     = SWRES_BIT + 1;
  localparam int OVR_BIT   = 0;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_ACCEPT,
    CLS_ABORT,
    CLS_KILL,
    CLS_RESET,
    CLS_REJECT
  } cmd_cls_e;
endpackage

// File: rtl/lin_cmd_classify.sv
module lin_cmd_classify
  import lin_busy_pkg::*;
(
  input  logic             ctrl_wr_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             en_i,
  input  logic             swres_i,
  input  logic             busy_i,
  output cmd_cls_e         cls_o
);
  always_comb begin
    cls_o = CLS_NONE;
    if (ctrl_wr_i) begin
      if (swres_i)                      cls_o = CLS_RESET;
      else if (!en_i || !cmd_i[CMD_W-1]) cls_o = CLS_KILL;
      else if (cmd_i[1:0] == 2'b00)     cls_o = CLS_ABORT;
      else if (busy_i)                  cls_o = CLS_REJECT;
      else                              cls_o = CLS_ACCEPT;
    end
  end
endmodule

// File: rtl/lin_wr_gate.sv
module lin_wr_gate #(
  parameter int              NREG      = 8,
  parameter logic [NREG-1:0] LOCK_MASK = '1,
  localparam int             AW        = $clog2(NREG)
) (
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            busy_i,
  output logic [NREG-1:0] we_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_we
    if (LOCK_MASK[g]) begin : g_locked
      assign we_o[g] = wr_en_i && (addr_i == AW'(g)) && !busy_i;
    end else begin : g_open
      assign we_o[g] = wr_en_i && (addr_i == AW'(g));
    end
  end
endmodule

// File: rtl/lin_ovr_flag.sv
module lin_ovr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic flush_i,
  output logic ovr_o
);
  logic ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovr_q <= 1'b0;
    else if (flush_i) ovr_q <= 1'b0;
    else if (set_i)   ovr_q <= 1'b1;
    else if (clr_i)   ovr_q <= 1'b0;
  end

  assign ovr_o = ovr_q;

  assert_reject_sets_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !flush_i |=> ovr_q);

  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && !clr_i && !flush_i |=> ovr_q);
endmodule

// File: rtl/lin_busy_ctrl.sv
module lin_busy_ctrl
  import lin_busy_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_cls_e         cls_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             en_i,
  input  logic             tx_start_i,
  input  logic             tx_done_i,
  output logic             busy_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             en_o,
  output logic             kill_o,
  output logic             abort_o,
  output logic             reset_o
);
  logic             busy_q, busy_d;
  logic             pend_q, pend_d;
  logic             kill_q, abort_q, reset_q;
  logic [CMD_W-1:0] cmd_q;
  logic             en_q;
  logic             do_kill, do_reset, do_abort, fire;

  assign do_kill  = (cls_i == CLS_KILL);
  assign do_reset = (cls_i == CLS_RESET);
  assign do_abort = (cls_i == CLS_ABORT);

  always_comb begin
    busy_d = busy_q;
    pend_d = pend_q;
    fire   = 1'b0;
    if (do_reset || do_kill) begin
      busy_d = 1'b0;
      pend_d = 1'b0;
    end else begin
      if (do_abort && !busy_q) fire   = 1'b1;
      else if (do_abort)       pend_d = 1'b1;
      // deferred abort lands on the byte boundary
      if (busy_q && tx_done_i) begin
        fire   = fire | pend_d;
        pend_d = 1'b0;
      end
      if (tx_start_i)          busy_d = 1'b1;
      else if (tx_done_i)      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      kill_q  <= 1'b0;
      abort_q <= 1'b0;
      reset_q <= 1'b0;
      cmd_q   <= '0;
      en_q    <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      pend_q  <= pend_d;
      kill_q  <= do_kill;
      abort_q <= fire;
      reset_q <= do_reset;
      if (do_reset) begin
        cmd_q <= '0;
        en_q  <= 1'b0;
      end else if (do_kill || do_abort || cls_i == CLS_ACCEPT) begin
        cmd_q <= cmd_i;
        en_q  <= en_i;
      end
    end
  end

  assign busy_o  = busy_q;
  assign cmd_o   = cmd_q;
  assign en_o    = en_q;
  assign kill_o  = kill_q;
  assign abort_o = abort_q;
  assign reset_o = reset_q;

  assert_start_sets_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_i && !do_kill && !do_reset |=> busy_q);

  assert_done_clears_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i && !tx_start_i |=> !busy_q);

  assert_reject_keeps_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls_i == CLS_REJECT |=> $stable(cmd_q) && $stable(en_q));

  assert_pend_needs_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> busy_q);

  assert_strobes_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({kill_q, abort_q, reset_q}));

  assert_kill_drops_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_kill |=> !busy_q && !pend_q && kill_q && !abort_q);

  assert_reset_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_reset |=> !busy_q && !pend_q && cmd_q == '0 && !en_q && !kill_q);
endmodule

// File: rtl/lin_busy_gate.sv
module lin_busy_gate
  import lin_busy_pkg::*;
#(
  parameter int              NREG      = 8,
  parameter int              CTRL_IDX  = 0,
  parameter int              ERR_IDX   = 1,
  parameter logic [NREG-1:0] LOCK_MASK = 8'hBD,
  localparam int             AW        = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [FLD_W-1:0] wr_data_i,
  input  logic             tx_start_i,
  input  logic             tx_done_i,
  input  logic             rx_byte_i,
  output logic             busy_o,
  output logic [NREG-1:0]  we_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             enable_o,
  output logic             ovr_err_o,
  output logic             kill_o,
  output logic             abort_o,
  output logic             reset_o
);
  cmd_cls_e cls;
  logic     ctrl_wr, err_clr, busy;

  assign ctrl_wr = wr_en_i && (wr_addr_i == AW'(CTRL_IDX));
  assign err_clr = wr_en_i && (wr_addr_i == AW'(ERR_IDX)) && wr_data_i[OVR_BIT];

  lin_cmd_classify i_classify (
    .ctrl_wr_i (ctrl_wr),
    .cmd_i     (wr_data_i[CMD_W-1:0]),
    .en_i      (wr_data_i[EN_BIT]),
    .swres_i   (wr_data_i[SWRES_BIT]),
    .busy_i    (busy),
    .cls_o     (cls)
  );

  lin_busy_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cls_i      (cls),
    .cmd_i      (wr_data_i[CMD_W-1:0]),
    .en_i       (wr_data_i[EN_BIT]),
    .tx_start_i (tx_start_i),
    .tx_done_i  (tx_done_i),
    .busy_o     (busy),
    .cmd_o      (cmd_o),
    .en_o       (enable_o),
    .kill_o     (kill_o),
    .abort_o    (abort_o),
    .reset_o    (reset_o)
  );

  lin_wr_gate #(.NREG(NREG), .LOCK_MASK(LOCK_MASK)) i_gate (
    .wr_en_i (wr_en_i),
    .addr_i  (wr_addr_i),
    .busy_i  (busy),
    .we_o    (we_o)
  );

  lin_ovr_flag i_ovr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (cls == CLS_REJECT),
    .clr_i   (err_clr),
    .flush_i (cls == CLS_RESET),
    .ovr_o   (ovr_err_o)
  );

  assign busy_o = busy;

  assert_rx_no_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_byte_i && !busy && !tx_start_i |=> !busy);

  assert_locked_when_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (we_o & LOCK_MASK) == '0);

  assert_reset_state_R10: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !ovr_err_o && !kill_o && !abort_o && !reset_o);
endmodule

// File: tb/test_lin_busy_gate.sv
module test_lin_busy_gate;
  localparam int CLK_P = 10;
  localparam int NV    = 23;

  // {rx, op, addr, data, we, busy, ovr, kill, abort, reset, cmd, en, req}
  // op: 0 idle, 1 write, 2 tx start, 3 tx done
  localparam logic [34:0] VECS [NV] = '{
    {1'b0,2'd1,3'd0,8'h0D,8'h01,1'b0,1'b0,1'b0,1'b0,1'b0,3'd5,1'b1,4'd9}, // R9 idle accept
    {1'b0,2'd1,3'd2,8'h13,8'h04,1'b0,1'b0,1'b0,1'b0,1'b0,3'd5,1'b1,4'd3}, // R3 idle write
    {1'b0,2'd2,3'd0,8'h00,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,3'd5,1'b1,4'd1}, // R1 start
    {1'b1,2'd0,3'd0,8'h00,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,3'd5,1'b1,4'd2}, // R2 rx while busy
    {1'b0,2'd1,3'd7,8'h05,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,3'd5,1'b1,4'd3}, // R3 data locked
    {1'b0,2'd1,3'd6,8'h0A,8'h40,1'b1,1'b0,1'b0,1'b0,1'b0,3'd5,1'b1,4'd3}, // R3 spare open
    {1'b0,2'd1,3'd0,8'h0E,8'h00,1'b1,1'b1,1'b0,1'b0,1'b0,3'd5,1'b1,4'd4}, // R4 refused
    {1'b0,2'd1,3'd1,8'h00,8'h02,1'b1,1'b1,1'b0,1'b0,1'b0,3'd5,1'b1,4'd5}, // R5 zero keeps
    {1'b0,2'd1,3'd1,8'h01,8'h02,1'b1,1'b0,1'b0,1'b0,1'b0,3'd5,1'b1,4'd5}, // R5 w1c
    {1'b0,2'd1,3'd0,8'h0C,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,3'd4,1'b1,4'd6}, // R6 abort deferred
    {1'b0,2'd0,3'd0,8'h00,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,3'd4,1'b1,4'd6}, // R6 still held
    {1'b0,2'd3,3'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b1,1'b0,3'd4,1'b1,4'd6}, // R6 fires at end
    {1'b0,2'd0,3'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,3'd4,1'b1,4'd6}, // R6 single pulse
    {1'b1,2'd0,3'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,3'd4,1'b1,4'd2}, // R2 rx idle
    {1'b0,2'd2,3'd0,8'h00,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,3'd4,1'b1,4'd1}, // R1 start
    {1'b0,2'd1,3'd0,8'h08,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,1'b1,4'd7}, // R7 kill busy
    {1'b0,2'd0,3'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,4'd7}, // R7 pulse ends
    {1'b0,2'd2,3'd0,8'h00,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,4'd1}, // R1 start
    {1'b0,2'd1,3'd0,8'h0D,8'h00,1'b1,1'b1,1'b0,1'b0,1'b0,3'd0,1'b1,4'd4}, // R4 refused
    {1'b0,2'd1,3'd0,8'h1D,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,3'd0,1'b0,4'd8}, // R8 soft reset
    {1'b0,2'd0,3'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,4'd8}, // R8 pulse ends
    {1'b0,2'd1,3'd0,8'h0C,8'h01,1'b0,1'b0,1'b0,1'b1,1'b0,3'd4,1'b1,4'd6}, // R6 idle abort
    {1'b0,2'd0,3'd0,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,3'd4,1'b1,4'd6}  // R6 pulse ends
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [4:0] wr_data_i = '0;
  logic       tx_start_i = 1'b0, tx_done_i = 1'b0, rx_byte_i = 1'b0;
  logic       busy_o, enable_o, ovr_err_o, kill_o, abort_o, reset_o;
  logic [7:0] we_o;
  logic [2:0] cmd_o;
  logic [7:0] we_seen;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  lin_busy_gate i_lin_busy_gate (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .tx_start_i, .tx_done_i, .rx_byte_i,
    .busy_o, .we_o, .cmd_o, .enable_o, .ovr_err_o,
    .kill_o, .abort_o, .reset_o
  );

  task automatic chk(input string what, input int req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [2:0] a, input logic [4:0] d,
                      input logic st, input logic dn, input logic rx);
    @(negedge clk_i);
    wr_en_i = wr; wr_addr_i = a; wr_data_i = d;
    tx_start_i = st; tx_done_i = dn; rx_byte_i = rx;
    #(CLK_P/4);
    we_seen = we_o;
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0; tx_start_i = 1'b0; tx_done_i = 1'b0; rx_byte_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P*3 + 2);
    // R10 reset state
    chk("reset busy", 10, busy_o, 0);
    chk("reset ovr", 10, ovr_err_o, 0);
    chk("reset strobes", 10, {kill_o, abort_o, reset_o}, 0);
    chk("reset cmd/en", 10, {cmd_o, enable_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      int          r;
      v = VECS[i];
      r = int'(v[3:0]);
      step(v[33:32] == 2'd1, v[31:29], v[25:21], v[33:32] == 2'd2, v[33:32] == 2'd3, v[34]);
      chk($sformatf("vec %0d we", i), r, we_seen, v[20:13]);
      chk($sformatf("vec %0d busy", i), r, busy_o, v[12]);
      chk($sformatf("vec %0d ovr", i), r, ovr_err_o, v[11]);
      chk($sformatf("vec %0d kill", i), r, kill_o, v[10]);
      chk($sformatf("vec %0d abort", i), r, abort_o, v[9]);
      chk($sformatf("vec %0d reset", i), r, reset_o, v[8]);
      chk($sformatf("vec %0d cmd", i), r, cmd_o, v[7:5]);
      chk($sformatf("vec %0d en", i), r, enable_o, v[4]);
    end

    // R7 kill by enable low discards a pending abort
    step(1'b0, 3'd0, 5'h00, 1'b1, 1'b0, 1'b0);
    step(1'b1, 3'd0, 5'h0C, 1'b0, 1'b0, 1'b0);
    chk("pending held busy", 6, busy_o, 1);
    step(1'b1, 3'd0, 5'h05, 1'b0, 1'b0, 1'b0);
    chk("kill en low", 7, kill_o, 1);
    chk("kill busy", 7, busy_o, 0);
    chk("kill no abort", 7, abort_o, 0);
    step(1'b0, 3'd0, 5'h00, 1'b0, 1'b1, 1'b0);
    chk("abort discarded", 7, abort_o, 0);

    // R7 kill wins over a start in the same cycle
    step(1'b1, 3'd0, 5'h08, 1'b1, 1'b0, 1'b0);
    chk("kill vs start busy", 7, busy_o, 0);
    chk("kill vs start strobe", 7, kill_o, 1);

    // R8 soft reset wins over kill, clears error
    step(1'b0, 3'd0, 5'h00, 1'b1, 1'b0, 1'b0);
    step(1'b1, 3'd0, 5'h0F, 1'b0, 1'b0, 1'b0);
    chk("refused sets ovr", 4, ovr_err_o, 1);
    step(1'b1, 3'd0, 5'h10, 1'b0, 1'b0, 1'b0);
    chk("reset over kill", 8, {kill_o, reset_o}, 1);
    chk("reset clears ovr", 8, ovr_err_o, 0);
    chk("reset clears busy", 8, busy_o, 0);

    // R1 busy spans a long byte
    step(1'b0, 3'd0, 5'h00, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) step(1'b0, 3'd0, 5'h00, 1'b0, 1'b0, 1'b1);
    chk("busy held", 1, busy_o, 1);
    step(1'b0, 3'd0, 5'h00, 1'b0, 1'b1, 1'b0);
    chk("busy released", 1, busy_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule